// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block connects a parallel datapath to a frame-synchronous, time-division multiplexed serial PCM bus. The bus carries a bit clock and a frame sync. A rising edge of the frame sync marks the start of a frame. The frame is divided into consecutive slots of `WORD_W` bit periods each, numbered from 1. In every frame the port receives one word from the serial input in the slot chosen for reception. It sends one word on the serial output in the slot chosen for transmission. The two slot choices are independent, and a choice of 0 switches that direction off.

All logic runs on one fast system clock. The bit clock, frame sync and serial input pass through a synchronizer of `SYNC_STAGES` flops and are then edge-detected, so the bit clock must be several times slower than the system clock. Input bits are taken on bit-clock falling edges. Output bits change on bit-clock rising edges. Words travel MSB first in both directions. The serial output is modelled as a data bit plus an active-high enable, for an open-drain or tri-state pad. The enable is high only during the bit periods of the transmit slot, and the data bit is 1 whenever the enable is low. A power-down input keeps the output released and stops both directions.

The parallel side has no back-pressure, because bus timing cannot be stalled. `rx_valid` is a single-cycle strobe, and the consumer must take `rx_data` in that cycle. `rx_data` then holds until the next strobe. On the transmit side, `tx_take` is a single-cycle acknowledge that fires when `tx_data` is copied into the shifter at the start of the slot. The source must present the word before its slot begins. Changes after `tx_take` reach the bus only in a later frame.

Top module: `pcm_tsp`

## Requirements
- R1: After reset, until the first rising edge of `frm_sync` is seen, `ser_oe` is 0, `ser_out` is 1, and neither `rx_valid` nor `tx_take` pulses, whatever the slot selects are.
- R2: With `rx_slot` = N (1..N_max), the bits sampled on the bit-clock falling edges at positions WORD_W×(N−1) through WORD_W×N−1 are assembled MSB first. Position 0 is the falling edge of the bit period in which `frm_sync` rose. The word appears on `rx_data` with a `rx_valid` strobe after its last bit, and `rx_data` changes at no other time.
- R3: With `tx_slot` = N (1..N_max), `ser_oe` is 1 for exactly the bit periods at positions WORD_W×(N−1) through WORD_W×N−1. `ser_out` carries the latched word MSB first, changing after each bit-clock rising edge. `tx_take` pulses as the first bit is launched.
- R4: A slot select of 0 disables that direction: no receive strobe, or no drive and no `tx_take`.
- R5: Whenever `ser_oe` is 0, `ser_out` is 1.
- R6: While `pwr_dn` is 1, `ser_oe` is 0 and no `rx_valid` or `tx_take` pulse occurs. Both directions work again in the next frame after it is cleared.
- R7: Every rising edge of `frm_sync` restarts bit counting at position 0, even in the middle of a frame or a slot.
- R8: Each slot select is sampled at the frame start and holds for that frame. The transmit word is sampled at `tx_take`, and later changes of `tx_data` do not alter the word being sent.
- R9: `rx_valid` and `tx_take` are one system-clock cycle long, at most once per slot. A receive word cut short by a frame restart or power-down gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock |
| frm_sync | input | 1 | Frame sync; its rising edge marks position 0 |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data, 1 while released |
| ser_oe | output | 1 | Output enable for the pad driver |
| pwr_dn | input | 1 | Power-down: release output, stop both directions |
| rx_slot | input | SEL_W | Receive slot select, 0 = off |
| tx_slot | input | SEL_W | Transmit slot select, 0 = off |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | Single-cycle strobe for a new `rx_data` |
| tx_data | input | WORD_W | Word to transmit in the next transmit slot |
| tx_take | output | 1 | Single-cycle strobe: `tx_data` was latched |

## Verification
The bench builds the port with its default parameters: 8-bit words, seven slots, 3-bit selects and a two-flop synchronizer. These settings reach the highest slot, whose last bit sits just below the saturation point of the position counter, and every pairing of receive and transmit slots in the sweep. The bit clock runs at one twelfth of the system clock, so synchronizer and pipeline latency fall well inside each bit half-period. Frame restarts are placed inside a receive slot and inside a transmit slot, which exercises the cut-word cases.

// File: rtl/pcm_tsp_pkg.sv
package pcm_tsp_pkg;

  // Where the current bit lies relative to the selected slot.
  typedef struct packed {
    logic hit;    // bit belongs to the selected slot
    logic first;  // MSB position of the slot
    logic last;   // LSB position of the slot
  } slot_pos_t;

endpackage

// File: rtl/pcm_tsp_sync.sv
// Synchronizes the bus inputs into the system clock domain and derives
// single-cycle bit-clock edge pulses aligned with the synchronized data.
module pcm_tsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  input  logic frm_sync,
  input  logic ser_in,
  output logic rise,
  output logic fall,
  output logic fs_s,
  output logic din_smp
);

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    logic [2:0] q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 3'b001;
        else        q <= {bit_clk, frm_sync, ser_in};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 3'b001;
        else        q <= g_st[i-1].q;
      end
    end
  end

  logic [2:0] tail;
  logic       bclk_d;

  assign tail = g_st[STAGES-1].q;
  assign rise = tail[2] & ~bclk_d;
  assign fall = ~tail[2] & bclk_d;
  assign fs_s = tail[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      din_smp <= 1'b1;
    end else begin
      bclk_d <= tail[2];
      if (fall) din_smp <= tail[0];
    end
  end

endmodule

// File: rtl/pcm_tsp_timebase.sv
// Bit position counter for one direction. Restarts at every frame-sync
// rising edge, saturates at an idle value past the last slot, and latches
// the slot select at frame start. One cycle after each step pulse, adv is
// high and pos/slot information describe the bit just stepped to.
module pcm_tsp_timebase
  import pcm_tsp_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SLOTS  = 7,
  parameter int SEL_W  = 3,
  parameter int POS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             fs_s,
  input  logic [SEL_W-1:0] sel_in,
  output logic             adv,
  output slot_pos_t        sp
);

  localparam logic [POS_W-1:0] IDLE_POS = POS_W'(SLOTS * WORD_W);
  localparam logic [POS_W-1:0] W_POS    = POS_W'(WORD_W);
  localparam logic [POS_W-1:0] W_LAST   = POS_W'(WORD_W - 1);

  logic             fs_last;
  logic [POS_W-1:0] pos_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_last <= 1'b0;
      pos_q   <= IDLE_POS;
      sel_q   <= '0;
      adv     <= 1'b0;
    end else begin
      adv <= step;
      if (step) begin
        fs_last <= fs_s;
        if (fs_s && !fs_last) begin
          pos_q <= '0;
          sel_q <= sel_in;
        end else if (pos_q != IDLE_POS) begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  logic [SLOTS-1:0] win, at_first, at_last;

  // Offset from each slot base; wraps far above WORD_W when below the base.
  for (genvar s = 0; s < SLOTS; s++) begin : g_win
    localparam logic [POS_W-1:0] LO = POS_W'(s * WORD_W);
    logic [POS_W-1:0] off;
    assign off         = pos_q - LO;
    assign win[s]      = off < W_POS;
    assign at_first[s] = off == '0;
    assign at_last[s]  = off == W_LAST;
  end

  always_comb begin
    sp = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (sel_q == SEL_W'(s + 1)) begin
        sp.hit   = win[s];
        sp.first = at_first[s];
        sp.last  = at_last[s];
      end
    end
  end

endmodule

// File: rtl/pcm_tsp_rx.sv
// Receive shifter: collects the bits of the selected slot MSB first and
// emits the word with a single-cycle strobe once all bits arrived intact.
module pcm_tsp_rx
  import pcm_tsp_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  slot_pos_t         sp,
  input  logic              din,
  input  logic              pwr_dn,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q
);

  logic [WORD_W-1:0] sh;
  logic              ok;
  logic              intact;

  assign intact = sp.first | ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      ok      <= 1'b0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (pwr_dn) begin
        ok <= 1'b0;
      end else if (adv) begin
        if (sp.hit) begin
          sh <= {sh[WORD_W-2:0], din};
          ok <= intact & ~sp.last;
          if (sp.last && intact) begin
            word_q  <= {sh[WORD_W-2:0], din};
            valid_q <= 1'b1;
          end
        end else begin
          ok <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_tsp_tx.sv
// Transmit shifter: latches the parallel word at the slot's first bit and
// launches one bit per rising-edge step; releases the line outside the slot.
module pcm_tsp_tx
  import pcm_tsp_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  slot_pos_t         sp,
  input  logic [WORD_W-1:0] word,
  input  logic              pwr_dn,
  output logic              dout_q,
  output logic              oe_q,
  output logic              take_q
);

  logic [WORD_W-1:0] sh;
  logic              ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      ok     <= 1'b0;
      dout_q <= 1'b1;
      oe_q   <= 1'b0;
      take_q <= 1'b0;
    end else begin
      take_q <= 1'b0;
      if (pwr_dn) begin
        ok     <= 1'b0;
        oe_q   <= 1'b0;
        dout_q <= 1'b1;
      end else if (adv) begin
        if (sp.hit && (sp.first || ok)) begin
          oe_q <= 1'b1;
          ok   <= ~sp.last;
          if (sp.first) begin
            dout_q <= word[WORD_W-1];
            sh     <= {word[WORD_W-2:0], 1'b0};
            take_q <= 1'b1;
          end else begin
            dout_q <= sh[WORD_W-1];
            sh     <= {sh[WORD_W-2:0], 1'b0};
          end
        end else begin
          ok     <= 1'b0;
          oe_q   <= 1'b0;
          dout_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_tsp.sv
// Bidirectional PCM time-slot serial port.
module pcm_tsp
  import pcm_tsp_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SLOTS       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              frm_sync,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              ser_oe,
  input  logic              pwr_dn,
  input  logic [SEL_W-1:0]  rx_slot,
  input  logic [SEL_W-1:0]  tx_slot,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_take
);

  localparam int POS_W = $clog2(SLOTS * WORD_W + 1);

  logic      rise, fall, fs_s, din_smp;
  logic      rx_adv, tx_adv;
  slot_pos_t rx_sp, tx_sp;
  logic      tx_bit, tx_oe;

  pcm_tsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_clk (bit_clk),
    .frm_sync(frm_sync),
    .ser_in  (ser_in),
    .rise    (rise),
    .fall    (fall),
    .fs_s    (fs_s),
    .din_smp (din_smp)
  );

  // Receive side counts falling edges, transmit side counts rising edges.
  pcm_tsp_timebase #(
    .WORD_W(WORD_W), .SLOTS(SLOTS), .SEL_W(SEL_W), .POS_W(POS_W)
  ) u_rx_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (fall),
    .fs_s  (fs_s),
    .sel_in(rx_slot),
    .adv   (rx_adv),
    .sp    (rx_sp)
  );

  pcm_tsp_timebase #(
    .WORD_W(WORD_W), .SLOTS(SLOTS), .SEL_W(SEL_W), .POS_W(POS_W)
  ) u_tx_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (rise),
    .fs_s  (fs_s),
    .sel_in(tx_slot),
    .adv   (tx_adv),
    .sp    (tx_sp)
  );

  pcm_tsp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (rx_adv),
    .sp     (rx_sp),
    .din    (din_smp),
    .pwr_dn (pwr_dn),
    .word_q (rx_data),
    .valid_q(rx_valid)
  );

  pcm_tsp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (tx_adv),
    .sp    (tx_sp),
    .word  (tx_data),
    .pwr_dn(pwr_dn),
    .dout_q(tx_bit),
    .oe_q  (tx_oe),
    .take_q(tx_take)
  );

  // Power-down releases the pad at once, not only at the next bit step.
  assign ser_oe  = tx_oe & ~pwr_dn;
  assign ser_out = ser_oe ? tx_bit : 1'b1;

endmodule

// File: rtl/pcm_tsp_chk.sv
module pcm_tsp_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic              ser_oe,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              tx_take
);

  // R9: receive strobe lasts a single cycle
  assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9: transmit acknowledge lasts a single cycle
  assert_take_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);

  // R2: the received word only moves together with its strobe
  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  // R3: the line is only ever claimed at a slot start where a word is latched
  assert_drive_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe) |-> tx_take);

  // R6: a port held in power-down produces no strobes
  assert_pd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_dn) && pwr_dn) |-> (!rx_valid && !tx_take));

endmodule

bind pcm_tsp pcm_tsp_chk #(.WORD_W(WORD_W)) i_pcm_tsp_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwr_dn  (pwr_dn),
  .ser_oe  (ser_oe),
  .rx_data (rx_data),
  .rx_valid(rx_valid),
  .tx_take (tx_take)
);

// File: tb/test_pcm_tsp.sv
`timescale 1ns/1ps
module test_pcm_tsp;

  localparam int W    = 8;
  localparam int NS   = 7;
  localparam int SW   = 3;
  localparam int HALF = 6;
  localparam int MAXB = 80;
  localparam int IDLE = NS * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_clk = 1'b0;
  logic frm_sync = 1'b0;
  logic ser_in = 1'b1;
  logic pwr_dn = 1'b0;
  logic [SW-1:0] rx_slot = '0;
  logic [SW-1:0] tx_slot = '0;
  logic [W-1:0]  tx_data = '0;
  logic          ser_out, ser_oe, rx_valid, tx_take;
  logic [W-1:0]  rx_data;

  always #4 clk = ~clk;

  pcm_tsp #(.WORD_W(W), .SLOTS(NS), .SYNC_STAGES(2)) i_pcm_tsp (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frm_sync(frm_sync),
    .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe), .pwr_dn(pwr_dn),
    .rx_slot(rx_slot), .tx_slot(tx_slot), .rx_data(rx_data),
    .rx_valid(rx_valid), .tx_data(tx_data), .tx_take(tx_take)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [MAXB-1:0] line;
  logic [MAXB-1:0] got_oe, got_sdo, exp_oe, exp_sdo;
  logic [W-1:0]    got_rx [4];
  logic [W-1:0]    exp_rx [4];
  int n_rx, e_rx, n_take, e_take, w_err;
  logic prev_rv, prev_tk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic watch();
    if (rx_valid) begin
      if (n_rx < 4) got_rx[n_rx] = rx_data;
      n_rx++;
    end
    if (tx_take) n_take++;
    if ((rx_valid && prev_rv) || (tx_take && prev_tk)) w_err++;
    prev_rv = rx_valid;
    prev_tk = tx_take;
  endtask

  task automatic half_bit();
    repeat (HALF) begin
      @(negedge clk);
      watch();
    end
  endtask

  // Drives nbits bit periods with frame syncs at fs_a/fs_b, optionally
  // changing selects and tx word at chg_at, and predicts every output.
  task automatic run_frame(input string req, input int nbits, input int fs_a,
                           input int fs_b, input int chg_at,
                           input logic [SW-1:0] nrx, input logic [SW-1:0] ntx,
                           input logic [W-1:0] nword);
    int pos = IDLE;
    int base, idx;
    logic [SW-1:0] mrs = '0;
    logic [SW-1:0] mts = '0;
    logic [W-1:0]  mw = '0;
    logic [W-1:0]  racc = '0;
    bit tok = 1'b0;
    bit rok = 1'b0;
    got_oe = '0; got_sdo = '1; exp_oe = '0; exp_sdo = '1;
    n_rx = 0; e_rx = 0; n_take = 0; e_take = 0; w_err = 0;
    prev_rv = 1'b0; prev_tk = 1'b0;
    for (int i = 0; i < 4; i++) begin
      got_rx[i] = '0;
      exp_rx[i] = '0;
    end
    for (int p = 0; p < nbits; p++) begin
      if (p == chg_at) begin
        rx_slot = nrx;
        tx_slot = ntx;
        tx_data = nword;
      end
      bit_clk  = 1'b1;
      frm_sync = (p == fs_a) || (p == fs_b);
      ser_in   = line[p];
      if ((p == fs_a) || (p == fs_b)) pos = 0;
      else if (pos < IDLE) pos++;
      if (pos == 0) begin
        mrs = rx_slot;
        mts = tx_slot;
      end
      base = (int'(mts) - 1) * W;
      if (pos < IDLE && mts != 0 && !pwr_dn && pos >= base && pos < base + W) begin
        idx = pos - base;
        if (idx == 0) begin
          mw = tx_data;
          tok = 1'b1;
          e_take++;
        end
        if (tok) begin
          exp_oe[p]  = 1'b1;
          exp_sdo[p] = mw[W-1-idx];
        end
      end else begin
        tok = 1'b0;
      end
      base = (int'(mrs) - 1) * W;
      if (pos < IDLE && mrs != 0 && !pwr_dn && pos >= base && pos < base + W) begin
        idx = pos - base;
        if (idx == 0) begin
          rok = 1'b1;
          racc = '0;
        end
        racc = {racc[W-2:0], line[p]};
        if (idx == W - 1 && rok) begin
          if (e_rx < 4) exp_rx[e_rx] = racc;
          e_rx++;
          rok = 1'b0;
        end
      end else begin
        rok = 1'b0;
      end
      half_bit();
      got_oe[p]  = ser_oe;
      got_sdo[p] = ser_out;
      bit_clk = 1'b0;
      half_bit();
    end
    frm_sync = 1'b0;
    chk(got_oe == exp_oe, req, "enable per bit", got_oe, exp_oe);
    chk(got_sdo == exp_sdo, req, "R5 line level per bit", got_sdo, exp_sdo);
    chk(n_rx == e_rx, req, "receive strobe count", n_rx, e_rx);
    for (int i = 0; i < 4; i++)
      if (i < e_rx) chk(got_rx[i] == exp_rx[i], req, "received word", got_rx[i], exp_rx[i]);
    chk(n_take == e_take, req, "transmit take count", n_take, e_take);
    chk(w_err == 0, req, "R9 strobe width", w_err, 0);
  endtask

  task automatic t_reset();
    chk(ser_oe == 1'b0, "R1", "enable after reset", ser_oe, 0);
    chk(ser_out == 1'b1, "R1", "line after reset", ser_out, 1);
    chk(rx_valid == 1'b0, "R1", "rx strobe after reset", rx_valid, 0);
    chk(tx_take == 1'b0, "R1", "take after reset", tx_take, 0);
    chk(rx_data == '0, "R1", "rx word after reset", rx_data, 0);
  endtask

  task automatic t_no_sync();
    rx_slot = 3'd1; tx_slot = 3'd1; tx_data = 8'h5A;
    line = 80'h1234_5678_9ABC_DEF0_0F1E;
    run_frame("R1 no frame sync", 24, -1, -1, -1, rx_slot, tx_slot, tx_data);
  endtask

  task automatic t_sweep();
    for (int k = 1; k <= NS; k++) begin
      rx_slot = SW'(k);
      tx_slot = SW'(NS + 1 - k);
      tx_data = 8'(8'h1B * k) ^ 8'hC6;
      line = 80'hF0E1_D2C3_B4A5_9687_7869 ^ {10{8'(k * 37)}};
      run_frame("R2 R3 slot sweep", 64, 0, -1, -1, rx_slot, tx_slot, tx_data);
    end
  endtask

  task automatic t_disabled();
    rx_slot = 3'd0; tx_slot = 3'd0; tx_data = 8'hFF;
    line = 80'hAAAA_5555_AAAA_5555_AAAA;
    run_frame("R4 R5 both off", 64, 0, -1, -1, rx_slot, tx_slot, tx_data);
    rx_slot = 3'd0; tx_slot = 3'd5; tx_data = 8'h81;
    run_frame("R4 rx off", 64, 0, -1, -1, rx_slot, tx_slot, tx_data);
  endtask

  task automatic t_power_down();
    pwr_dn = 1'b1;
    rx_slot = 3'd3; tx_slot = 3'd3; tx_data = 8'h00;
    line = 80'h0123_4567_89AB_CDEF_0123;
    run_frame("R6 powered down", 64, 0, -1, -1, rx_slot, tx_slot, tx_data);
    pwr_dn = 1'b0;
    run_frame("R6 after power-up", 64, 0, -1, -1, rx_slot, tx_slot, tx_data);
  endtask

  task automatic t_resync();
    rx_slot = 3'd1; tx_slot = 3'd2; tx_data = 8'hB7;
    line = 80'h3C5A_96E1_0FF0_C33C_7E81;
    run_frame("R7 cut in tx slot", 76, 0, 12, -1, rx_slot, tx_slot, tx_data);
    rx_slot = 3'd2; tx_slot = 3'd1; tx_data = 8'h4D;
    run_frame("R7 R9 cut in rx slot", 76, 0, 12, -1, rx_slot, tx_slot, tx_data);
  endtask

  task automatic t_hold();
    rx_slot = 3'd4; tx_slot = 3'd4; tx_data = 8'hE4;
    line = 80'h9D2B_6F10_C8A7_3E55_02F9;
    run_frame("R8 mid-frame change", 64, 0, -1, 27, 3'd2, 3'd6, 8'h1B);
    run_frame("R8 next frame", 64, 0, -1, -1, rx_slot, tx_slot, tx_data);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_no_sync();
    t_sweep();
    t_disabled();
    t_power_down();
    t_resync();
    t_hold();
    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule